// File: doc/BRIEF.md
# Centisecond Timekeeper with Selectable Reference Pulse

The block keeps time from a 76.8 kHz main clock. A prescaler divides the clock into centisecond ticks. These ticks drive a centisecond counter (0 to 99), and that counter carries into a seconds counter (0 to 59). Both counters run without pause.

From the same timebase the block drives one reference output, `ref_o`, at a rate chosen by a 2-bit select:

- a 32768 Hz pulse train, with 32 pulses spread across every 75 clock cycles;
- a 50 Hz square wave;
- a 2 Hz pulse;
- a once-per-minute pulse, which is held back while the receiver-enable input is high.

A host reads and loads the two time counters over a flat register port with an address, a write strobe and write data. Read data is combinational from the address.

Top module: `rtc_ref_top`

## Requirements
- R1: The centisecond counter advances once every `CLK_DIV` clock cycles and wraps from 99 to 0. The prescaler restarts from zero after any write to a time register.
- R2: The seconds counter advances when the centisecond counter wraps from 99 to 0, and it wraps from 59 to 0. It does not change at any other time except on a host write.
- R3: With select 0, an accumulator starts at 0 after reset and adds 32 modulo 75 on every cycle. `ref_o` is high for one cycle in the cycle after each wrap. This gives exactly 32 pulses in every 75 cycles, and no two pulses are adjacent.
- R4: With select 1, an internal square level starts at 0 and toggles on every centisecond advance. `ref_o` shows that level one cycle later, giving a 50 Hz square wave.
- R5: With select 2, `ref_o` is high for exactly one cycle: the first cycle in which the centisecond counter reads 0 or 50 after an advance.
- R6: With select 3, `ref_o` is high for one cycle: the first cycle after the seconds counter rolls from 59 to 0. The pulse is suppressed if `rx_en_i` was high in the clock cycle before that rollover.
- R7: Address 1 reads the seconds count in bits 5:0. Address 2 reads the centisecond count in bits 6:0. Unused read bits are 0, and any other address reads 0.
- R8: A write to address 1 loads seconds from `wdata_i[5:0]`, and a write to address 2 loads centiseconds from `wdata_i[6:0]`. Upper bits are ignored. A value above the counter's maximum loads 0. In a write cycle neither counter advances. Writes to any other address have no effect on time, prescaler or output.
- R9: During reset both counters, the prescaler, the accumulator, the square level and `ref_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 76.8 kHz main clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 2 | Reference rate: 0 fractional, 1 square, 2 half-second, 3 minute |
| rx_en_i | input | 1 | Receiver active; blocks the minute pulse |
| addr_i | input | ADDR_W | Register address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| ref_o | output | 1 | Reference output |

## Verification
The bench builds the block with `CLK_DIV` = 8 in place of 768, so a centisecond lasts 8 cycles and a whole minute lasts 48,000 cycles. At that setting a natural 59-to-0 seconds rollover, and the minute pulse it produces, fall inside the run without any host preload. The fractional 32-in-75 pattern does not depend on the divider and is checked at its true spacing. The short divider also makes writes land at many different prescaler phases during the random phase.

// File: rtl/rtc_ref_pkg.sv
package rtc_ref_pkg;
  typedef enum logic [1:0] {
    REF_FRAC   = 2'd0,
    REF_SQUARE = 2'd1,
    REF_HALF   = 2'd2,
    REF_MINUTE = 2'd3
  } ref_sel_e;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int CLK_DIV = 768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (clr_i)        cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  a_r1_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  a_r1_clr_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/rtc_frac_acc.sv
module rtc_frac_acc #(
  parameter int NUM = 32,
  parameter int DEN = 75
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic wrap_o
);
  localparam int AW = $clog2(DEN) + 1;
  localparam logic [AW-1:0] DEN_V = AW'(DEN);
  localparam logic [AW-1:0] NUM_V = AW'(NUM);

  logic [AW-1:0] acc_q, sum;

  assign sum    = acc_q + NUM_V;
  assign wrap_o = (sum >= DEN_V);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (wrap_o) acc_q <= sum - DEN_V;
    else             acc_q <= sum;
  end

  a_r3_acc_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q < DEN_V);

  // spacing guarantee only exists when the ratio is below one half
  if (2 * NUM < DEN) begin : g_spacing
    a_r3_no_adjacent: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wrap_o |=> !wrap_o);
  end
endmodule

// File: rtl/rtc_time.sv
module rtc_time #(
  parameter int CS_MAX  = 99,
  parameter int SEC_MAX = 59,
  localparam int CS_W   = $clog2(CS_MAX + 1),
  localparam int SEC_W  = $clog2(SEC_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_sec_i,
  input  logic             wr_cs_i,
  input  logic [7:0]       wdata_i,
  output logic [CS_W-1:0]  cs_o,
  output logic [SEC_W-1:0] sec_o,
  output logic             cs_wrap_o,
  output logic             min_wrap_o
);
  localparam logic [CS_W-1:0]  CS_LAST  = CS_W'(CS_MAX);
  localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_MAX);

  logic [CS_W-1:0]  cs_q, cs_wr;
  logic [SEC_W-1:0] sec_q, sec_wr;
  logic             adv;

  // out-of-range loads collapse to zero
  assign cs_wr  = (wdata_i[CS_W-1:0]  > CS_LAST)  ? '0 : wdata_i[CS_W-1:0];
  assign sec_wr = (wdata_i[SEC_W-1:0] > SEC_LAST) ? '0 : wdata_i[SEC_W-1:0];

  assign adv        = tick_i & ~wr_sec_i & ~wr_cs_i;
  assign cs_wrap_o  = adv & (cs_q == CS_LAST);
  assign min_wrap_o = cs_wrap_o & (sec_q == SEC_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q  <= '0;
      sec_q <= '0;
    end else begin
      if (wr_cs_i)        cs_q <= cs_wr;
      else if (cs_wrap_o) cs_q <= '0;
      else if (adv)       cs_q <= cs_q + 1'b1;

      if (wr_sec_i)        sec_q <= sec_wr;
      else if (min_wrap_o) sec_q <= '0;
      else if (cs_wrap_o)  sec_q <= sec_q + 1'b1;
    end
  end

  assign cs_o  = cs_q;
  assign sec_o = sec_q;

  a_r1_cs_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_q <= CS_LAST);
  a_r2_sec_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_q <= SEC_LAST);
  a_r2_sec_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_sec_i) |=> $stable(sec_q));
  a_r8_write_freezes_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sec_i && !wr_cs_i) |=> $stable(cs_q));
endmodule

// File: rtl/rtc_ref_top.sv
module rtc_ref_top
  import rtc_ref_pkg::*;
#(
  parameter int CLK_DIV  = 768,
  parameter int FRAC_NUM = 32,
  parameter int FRAC_DEN = 75,
  parameter int ADDR_W   = 8,
  parameter int ADDR_SEC = 1,
  parameter int ADDR_CS  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        sel_i,
  input  logic              rx_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              ref_o
);
  localparam int CS_W  = $clog2(100);
  localparam int SEC_W = $clog2(60);

  logic             wr_sec, wr_cs, wr_any, pre_tick, adv;
  logic             cs_wrap, min_wrap, frac_wrap, half_evt;
  logic [CS_W-1:0]  cs;
  logic [SEC_W-1:0] sec;
  logic             sq_q, ref_d, ref_q;
  ref_sel_e         sel;

  assign sel    = ref_sel_e'(sel_i);
  assign wr_sec = we_i & (addr_i == ADDR_W'(ADDR_SEC));
  assign wr_cs  = we_i & (addr_i == ADDR_W'(ADDR_CS));
  assign wr_any = wr_sec | wr_cs;
  assign adv    = pre_tick & ~wr_any;

  rtc_prescaler #(.CLK_DIV(CLK_DIV)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (wr_any),
    .tick_o(pre_tick)
  );

  rtc_time #(.CS_MAX(99), .SEC_MAX(59)) u_time (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (pre_tick),
    .wr_sec_i  (wr_sec),
    .wr_cs_i   (wr_cs),
    .wdata_i   (wdata_i),
    .cs_o      (cs),
    .sec_o     (sec),
    .cs_wrap_o (cs_wrap),
    .min_wrap_o(min_wrap)
  );

  rtc_frac_acc #(.NUM(FRAC_NUM), .DEN(FRAC_DEN)) u_frac (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wrap_o(frac_wrap)
  );

  // next count is 0 or 50
  assign half_evt = cs_wrap | (adv & (cs == CS_W'(49)));

  always_comb begin
    unique case (sel)
      REF_FRAC:   ref_d = frac_wrap;
      REF_SQUARE: ref_d = sq_q;
      REF_HALF:   ref_d = half_evt;
      REF_MINUTE: ref_d = min_wrap & ~rx_en_i;
      default:    ref_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sq_q  <= 1'b0;
      ref_q <= 1'b0;
    end else begin
      if (adv) sq_q <= ~sq_q;
      ref_q <= ref_d;
    end
  end

  assign ref_o = ref_q;

  always_comb begin
    if (addr_i == ADDR_W'(ADDR_SEC))     rdata_o = {{(8-SEC_W){1'b0}}, sec};
    else if (addr_i == ADDR_W'(ADDR_CS)) rdata_o = {{(8-CS_W){1'b0}}, cs};
    else                                 rdata_o = 8'h00;
  end

  a_r6_rx_blocks_minute: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == REF_MINUTE && rx_en_i) |=> !ref_o);
  a_r5_pulse_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_o && $stable(sel_i) && sel_i != REF_SQUARE) |=> !ref_o);
  a_r4_square_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == REF_SQUARE && !adv) |=> (ref_o == $past(sq_q)));
  a_r8_write_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_any && CLK_DIV > 1) |=> !pre_tick);
endmodule

// File: tb/tb_rtc_ref_top.sv
`timescale 1ns/1ps
module tb_rtc_ref_top;
  localparam int DIV = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sel = 2'd0;
  logic       rx_en = 1'b0;
  logic [7:0] addr = 8'd0;
  logic       we = 1'b0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       ref_out;

  int checks = 0;
  int errors = 0;
  int pulse_cnt = 0;

  // reference model state
  int  m_pre, m_cs, m_sec, m_acc;
  bit  m_sq, m_ref;

  always #2.5 clk = ~clk;

  rtc_ref_top #(.CLK_DIV(DIV)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .rx_en_i(rx_en),
    .addr_i(addr), .we_i(we), .wdata_i(wdata), .rdata_o(rdata), .ref_o(ref_out)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre <= 0; m_cs <= 0; m_sec <= 0; m_acc <= 0; m_sq <= 0; m_ref <= 0;
    end else begin
      bit ws, wc, tk, fr;
      int nx;
      ws = we && addr == 8'd1;
      wc = we && addr == 8'd2;
      tk = !(ws || wc) && m_pre == DIV - 1;
      m_pre <= (ws || wc || m_pre == DIV - 1) ? 0 : m_pre + 1;
      if (ws) m_sec <= (int'(wdata[5:0]) > 59) ? 0 : int'(wdata[5:0]);
      if (wc) m_cs  <= (int'(wdata[6:0]) > 99) ? 0 : int'(wdata[6:0]);
      if (tk) begin
        m_cs <= (m_cs == 99) ? 0 : m_cs + 1;
        if (m_cs == 99) m_sec <= (m_sec == 59) ? 0 : m_sec + 1;
        m_sq <= !m_sq;
      end
      nx = m_acc + 32;
      fr = nx >= 75;
      m_acc <= fr ? nx - 75 : nx;
      case (sel)
        2'd0: m_ref <= fr;
        2'd1: m_ref <= m_sq;
        2'd2: m_ref <= tk && (m_cs == 99 || m_cs == 49);
        default: m_ref <= tk && m_cs == 99 && m_sec == 59 && !rx_en;
      endcase
    end
  end

  function automatic int exp_rd(logic [7:0] a);
    if (a == 8'd1) return m_sec;
    if (a == 8'd2) return m_cs;
    return 0;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  string sel_tag [4] = '{"R3", "R4", "R5", "R6"};

  task automatic step();
    @(negedge clk);
    chk(ref_out == m_ref, sel_tag[sel], ref_out, m_ref);
    chk(int'(rdata) == exp_rd(addr), "R7", rdata, exp_rd(addr));
    if (ref_out) pulse_cnt++;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    step();
    we = 1'b0;
  endtask

  task automatic rd_chk(logic [7:0] a, int exp, string req);
    addr = a;
    #0.5;
    chk(int'(rdata) == exp, req, rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd5127));
    // R9 reset state
    repeat (3) @(negedge clk);
    chk(ref_out == 1'b0, "R9", ref_out, 0);
    rd_chk(8'd1, 0, "R9");
    rd_chk(8'd2, 0, "R9");
    rst_n = 1'b1;
    addr = 8'd0;

    // R8 field masking and out-of-range loads
    wr(8'd1, 8'hC5);
    rd_chk(8'd1, 5, "R8");
    wr(8'd2, 8'hA3);
    rd_chk(8'd2, 35, "R8");
    wr(8'd1, 8'd61);
    rd_chk(8'd1, 0, "R8");
    wr(8'd2, 8'd120);
    rd_chk(8'd2, 0, "R8");
    wr(8'd1, 8'd17);
    wr(8'd3, 8'd44);
    rd_chk(8'd1, 17, "R8");
    rd_chk(8'd3, 0, "R7");

    // R1 centisecond pace right after a write
    wr(8'd2, 8'd10);
    run(DIV - 1);
    rd_chk(8'd2, 10, "R1");
    step();
    rd_chk(8'd2, 11, "R1");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      step();
      we = 1'b0;
      if ($urandom % 150 == 0) sel = 2'($urandom);
      if ($urandom % 250 == 0) rx_en = !rx_en;
      addr = 8'($urandom % 4);
      if ($urandom % 60 == 0) begin
        wdata = 8'($urandom);
        we = 1'b1;
      end
    end
    we = 1'b0;

    // R3: 32 pulses in each 75-cycle window
    sel = 2'd0;
    step();
    pulse_cnt = 0;
    run(750);
    chk(pulse_cnt == 320, "R3", pulse_cnt, 320);

    // R5: two half-second pulses per centisecond wrap period
    sel = 2'd2;
    wr(8'd2, 8'd0);
    pulse_cnt = 0;
    run(100 * DIV + 5);
    chk(pulse_cnt == 2, "R5", pulse_cnt, 2);

    // R6: minute pulse issued, then blocked by receiver
    sel = 2'd3; rx_en = 1'b0;
    wr(8'd1, 8'd59);
    wr(8'd2, 8'd98);
    pulse_cnt = 0;
    run(4 * DIV);
    chk(pulse_cnt == 1, "R6", pulse_cnt, 1);
    rx_en = 1'b1;
    wr(8'd1, 8'd59);
    wr(8'd2, 8'd98);
    pulse_cnt = 0;
    run(4 * DIV);
    chk(pulse_cnt == 0, "R6", pulse_cnt, 0);
    rd_chk(8'd1, 0, "R2");

    // R2: natural full-minute rollover
    rx_en = 1'b0;
    wr(8'd1, 8'd0);
    wr(8'd2, 8'd0);
    pulse_cnt = 0;
    run(6000 * DIV + 10);
    chk(pulse_cnt == 1, "R2", pulse_cnt, 1);

    // R4: square wave period
    sel = 2'd1;
    wr(8'd2, 8'd0);
    pulse_cnt = 0;
    run(20 * DIV);
    chk(pulse_cnt == 10 * DIV, "R4", pulse_cnt, 10 * DIV);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule